// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits on the write datapath between a memory controller and its PHY, downstream of the ECC encoder. Software loads a set of corruption masks, and the next write transfer has those masks XORed onto the data and check bits of its first beat. The stored word then carries check bits that disagree with its data, so the error-reporting path and the driver software can be tested against known errors.

The write bus is beat-parallel. Beat 0 sits in the least significant slice of the bus and is the first beat in time. A start-of-transfer strobe marks the bus cycle that holds the first beat of a transfer. Several data-mask registers together cover the width of one beat, and one further register covers the check bits of that beat. Once a transfer has taken the masks, every mask register returns to zero on its own, so each mask setting yields exactly one faulty write.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset every mask register holds zero, so a transfer passes through with its data and check bits unchanged.
- R2: On a cycle with `in_valid` and `in_sop` both high, data-mask register k (selector value k, for k below NREG) is XORed onto bits [k*BEAT_W/NREG +: BEAT_W/NREG] of beat 0 of `out_data`. Data masks never change check bits.
- R3: On the same cycle, the check-bit mask (selector value NREG, taken from the low ECC_W bits of `cfg_wdata`) is XORed onto the ECC_W bits of beat 0 of `out_ecc`. It never changes data bits.
- R4: Every beat other than beat 0 passes through bit-identical, both data and check bits.
- R5: The clock edge that ends an injecting cycle clears every mask register, so the following transfer passes through unchanged unless software writes a mask again.
- R6: A cycle without both `in_valid` and `in_sop` high injects nothing and leaves the mask registers unchanged.
- R7: When software writes a mask register in the same cycle as an injecting transfer, that register takes the written value instead of clearing. The transfer in that cycle still uses the old value.
- R8: The path adds no latency. `out_valid` and `out_sop` equal `in_valid` and `in_sop` in the same cycle, and data with an all-zero mask leaves the bus bit-identical.
- R9: A write whose selector exceeds NREG changes no mask register.
- R10: A write to a mask register replaces its whole previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_sel | input | $clog2(NREG+1) | Register selector: 0..NREG-1 data masks, NREG check-bit mask |
| cfg_wdata | input | BEAT_W/NREG | Mask write value |
| in_valid | input | 1 | Write bus valid from the controller |
| in_sop | input | 1 | First-beat (start-of-transfer) strobe |
| in_data | input | BEATS*BEAT_W | Encoded write data, beat 0 in the low bits |
| in_ecc | input | BEATS*ECC_W | Check bits, beat 0 in the low bits |
| out_valid | output | 1 | Valid toward the PHY |
| out_sop | output | 1 | First-beat strobe toward the PHY |
| out_data | output | BEATS*BEAT_W | Write data with the fault applied |
| out_ecc | output | BEATS*ECC_W | Check bits with the fault applied |

## Verification
The bench goes after the one-shot behaviour. It sends a second transfer after every injection, and a design that failed to clear would corrupt that second transfer as well. It drives valid without the start strobe, and the start strobe without valid, and then confirms that the masks still apply afterwards. A design that keyed on only one of the two strobes would fire early or lose the mask. It collides a software write with an injecting transfer, where a wrong priority shows up as either a lost new mask or a mask that sticks. It also writes to an unused selector and checks mask isolation per field, which exposes a decoder that aliases registers or lets a data mask reach the check bits.

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector #(
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int ECC_W  = 8,
  parameter int NREG   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [$clog2(NREG+1)-1:0]       cfg_sel,
  input  logic [BEAT_W/NREG-1:0]          cfg_wdata,
  input  logic                            in_valid,
  input  logic                            in_sop,
  input  logic [BEATS*BEAT_W-1:0]         in_data,
  input  logic [BEATS*ECC_W-1:0]          in_ecc,
  output logic                            out_valid,
  output logic                            out_sop,
  output logic [BEATS*BEAT_W-1:0]         out_data,
  output logic [BEATS*ECC_W-1:0]          out_ecc
);
  localparam int SLICE_W = BEAT_W / NREG;
  localparam int SEL_W   = $clog2(NREG + 1);
  localparam int DW      = BEATS * BEAT_W;
  localparam int EW      = BEATS * ECC_W;

  logic [NREG-1:0][SLICE_W-1:0] dmask;
  logic [ECC_W-1:0]             emask;
  logic                         inject;
  logic [DW-1:0]                dpat;
  logic [EW-1:0]                epat;

  assign inject = in_valid & in_sop;

  for (genvar k = 0; k < NREG; k++) begin : g_dmask
    always_ff @(posedge clk) begin
      if (!rst_n)                                 dmask[k] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(k))    dmask[k] <= cfg_wdata;
      else if (inject)                            dmask[k] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   emask <= '0;
    else if (cfg_we && cfg_sel == SEL_W'(NREG))   emask <= cfg_wdata[ECC_W-1:0];
    else if (inject)                              emask <= '0;
  end

  always_comb begin
    dpat = '0;
    epat = '0;
    if (inject) begin
      dpat[BEAT_W-1:0] = dmask;
      epat[ECC_W-1:0]  = emask;
    end
  end

  assign out_valid = in_valid;
  assign out_sop   = in_sop;
  assign out_data  = in_data ^ dpat;
  assign out_ecc   = in_ecc ^ epat;

  AST_CLEAR_AFTER_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && !cfg_we) |=> (dmask == '0 && emask == '0)); // R5
  AST_HOLD_WITHOUT_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!inject && !cfg_we) |=> ($stable(dmask) && $stable(emask))); // R6
  AST_SW_WINS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(0)) |=> (dmask[0] == $past(cfg_wdata))); // R7
  AST_SW_WINS_ECC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(NREG)) |=> (emask == $past(cfg_wdata[ECC_W-1:0]))); // R7
  AST_LATER_BEATS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data[DW-1:BEAT_W] == in_data[DW-1:BEAT_W]) && (out_ecc[EW-1:ECC_W] == in_ecc[EW-1:ECC_W])); // R4
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !inject |-> (out_data == in_data && out_ecc == in_ecc)); // R6
  AST_NO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (out_sop == in_sop)); // R8
endmodule

// File: tb/ecc_fault_injector_tb_top.sv
module ecc_fault_injector_tb_top;
  localparam int BEAT_W = 16, BEATS = 2, ECC_W = 6, NREG = 2;
  localparam int SW = BEAT_W / NREG, DW = BEATS * BEAT_W, EW = BEATS * ECC_W;
  localparam int NV = 6;

  localparam logic [7:0]  VM0 [NV] = '{8'h00, 8'h01, 8'h00, 8'h00, 8'hA5, 8'hFF};
  localparam logic [7:0]  VM1 [NV] = '{8'h00, 8'h00, 8'h80, 8'h00, 8'h5A, 8'hFF};
  localparam logic [5:0]  VEM [NV] = '{6'h00, 6'h00, 6'h00, 6'h3F, 6'h21, 6'h3F};
  localparam logic [31:0] VD  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hFFFF0000,
                                       32'h00000000, 32'hCAFEF00D, 32'hFFFFFFFF};
  localparam logic [11:0] VE  [NV] = '{12'hABC, 12'h000, 12'hFFF, 12'h555, 12'h0F0, 12'hFFF};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [SW-1:0] cfg_wdata = '0;
  logic in_valid = 0, in_sop = 0;
  logic [DW-1:0] in_data = '0;
  logic [EW-1:0] in_ecc = '0;
  logic out_valid, out_sop;
  logic [DW-1:0] out_data;
  logic [EW-1:0] out_ecc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_fault_injector #(.BEAT_W(BEAT_W), .BEATS(BEATS), .ECC_W(ECC_W), .NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_ecc(in_ecc),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .out_ecc(out_ecc));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [SW-1:0] val);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drive(input logic v, input logic s, input logic [DW-1:0] d, input logic [EW-1:0] e);
    in_valid = v; in_sop = s; in_data = d; in_ecc = e;
    #1;
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 0; in_sop = 0;
  endtask

  task automatic clean_xfer(input string tag, input logic [DW-1:0] d, input logic [EW-1:0] e);
    drive(1, 1, d, e);
    chk({tag, " data"}, 64'(out_data), 64'(d));
    chk({tag, " ecc"}, 64'(out_ecc), 64'(e));
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    drive(1, 1, 32'hA5A5A5A5, 12'h3C3);
    chk("R1 data after reset", 64'(out_data), 64'h A5A5A5A5);
    chk("R1 ecc after reset", 64'(out_ecc), 64'h3C3);
    chk("R8 valid", 64'(out_valid), 64'd1);
    rst_n = 1;
    idle();

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VM0[i]); wr(2'd1, VM1[i]); wr(2'd2, {2'b00, VEM[i]});
      drive(1, 1, VD[i], VE[i]);
      chk("R2 data beat0", 64'(out_data[15:0]), 64'(VD[i][15:0] ^ {VM1[i], VM0[i]}));
      chk("R4 data beat1", 64'(out_data[31:16]), 64'(VD[i][31:16]));
      chk("R3 ecc beat0", 64'(out_ecc[5:0]), 64'(VE[i][5:0] ^ VEM[i]));
      chk("R4 ecc beat1", 64'(out_ecc[11:6]), 64'(VE[i][11:6]));
      chk("R8 sop", 64'(out_sop), 64'd1);
      idle();
      clean_xfer("R5 follow-up", VD[i], VE[i]);
    end

    // R6: valid without sop, sop without valid
    wr(2'd0, 8'h0F); wr(2'd2, 6'h11);
    drive(1, 0, 32'h11112222, 12'h123);
    chk("R6 no sop data", 64'(out_data), 64'h11112222);
    chk("R6 no sop ecc", 64'(out_ecc), 64'h123);
    idle();
    drive(0, 1, 32'h33334444, 12'h456);
    chk("R8 valid low", 64'(out_valid), 64'd0);
    chk("R6 no valid data", 64'(out_data), 64'h33334444);
    idle();
    drive(1, 1, 32'h00000000, 12'h000);
    chk("R6 mask retained data", 64'(out_data), 64'h0000000F);
    chk("R6 mask retained ecc", 64'(out_ecc), 64'h011);
    idle();

    // R7: software write collides with injection
    wr(2'd0, 8'h3C); wr(2'd1, 8'h77);
    cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 8'h5A;
    drive(1, 1, 32'h0, 12'h0);
    chk("R7 old mask used", 64'(out_data), 64'h0000773C);
    @(negedge clk);
    cfg_we = 0; in_valid = 0; in_sop = 0;
    drive(1, 1, 32'h0, 12'h0);
    chk("R7 new mask kept, other cleared", 64'(out_data), 64'h0000005A);
    chk("R7 ecc cleared", 64'(out_ecc), 64'h0);
    idle();
    clean_xfer("R5 after collision", 32'h0, 12'h0);

    // R9: out-of-range selector
    wr(2'd3, 8'hFF);
    clean_xfer("R9 ignored selector", 32'h89ABCDEF, 12'h777);

    // R10: overwrite replaces
    wr(2'd1, 8'hF0); wr(2'd1, 8'h03);
    drive(1, 1, 32'h0, 12'h0);
    chk("R10 overwrite", 64'(out_data), 64'h00000300);
    idle();

    // R1: reset clears loaded masks
    wr(2'd0, 8'hFF); wr(2'd2, 6'h3F);
    rst_n = 0; @(negedge clk); rst_n = 1;
    clean_xfer("R1 reset clears", 32'h55555555, 12'hAAA);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule